// File: doc/BRIEF.md
# Routed Token Sequencer

A control sequencer made of a row of single-bit stages that carry one active token. Every stage is a register that delays by one clock. On each edge a stage becomes set when any stage holding the token has its currently chosen outgoing link pointing at it. The set of links that exist is fixed when the block is built, through a connection parameter. The choice among them is made at run time by outside control logic, through a one-hot route select for each stage.

A link may lead to another stage, back to the same stage, or to one of several exit ports. A link back to the same stage holds the token. While every stage is clear, the network is idle. A start pulse loads the entry stage of that start input. The run ends when the token leaves through an exit port. At that point a one-clock done pulse and the exit number are reported, and the network returns to all-zero. Force inputs set or clear individual stage bits so that a downstream checker can be tested with injected faults.

Top module: `tseq_network`

## Requirements
- R1: While `rst_ni` is low, every stage bit and `done_o` are 0, and they stay 0 after reset is released until a start pulse arrives.
- R2: When all stage bits are 0, a 1 on start bit s sets the entry stage of that start on the next edge. By default, start 0 enters stage 0 and start 1 enters stage 2. Starts that arrive together each load their own entry stage.
- R3: A start pulse has no effect while any stage bit is 1.
- R4: Stage j is 1 after an edge exactly when some stage i held the token before the edge, and the route select of i chose destination j, and the link i to j exists. Destination codes 0..N-1 name stages, and code N+e names exit e. In `sel_i`, the select of stage i is the slice [i*(N+E) +: N+E], with bit d meaning destination d.
- R5: A stage whose select chooses its own index keeps the token.
- R6: If the select chooses a link that does not exist, the token is dropped and no done pulse follows.
- R7: A token routed to exit e clears its stage. On the next clock `done_o` is 1 for one cycle and `exit_o` equals e.
- R8: If tokens reach several exits on the same edge, one done pulse reports the lowest exit number.
- R9: `force_set_i[j]` makes stage j 1 after the edge, and `force_clr_i[j]` makes it 0. Clear wins over set.
- R10: The default links are as follows. Every stage may go to itself. Stage i may go to stage i+1 for i<N-1. The last stage may go to every exit. Stage 1 may also go to the last exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | N_STARTS | Start pulses, one per entry |
| sel_i | input | N_STAGES*(N_STAGES+N_EXITS) | One-hot route select per stage |
| force_set_i | input | N_STAGES | Fault injection: force stage bit to 1 |
| force_clr_i | input | N_STAGES | Fault injection: force stage bit to 0 |
| tok_o | output | N_STAGES | Stage register contents |
| done_o | output | 1 | One-cycle pulse when a token exits |
| exit_o | output | EXIT_W | Exit number that produced the done pulse |

## Verification
Correct routing never produces two tokens at once, so the hardest case to reach is two tokens leaving through different exits on the same edge. The bench reaches it with a forced set of the last stage while the real token sits in stage 1. It then routes both tokens to exits in the same cycle and checks that the lower exit number is reported. Dropped tokens are reached by selecting a link that the connection map lacks. Ignored starts are reached by pulsing start in the middle of a run.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int unsigned MAP_MAX = 1024;

  // chain with self-loops, last stage to every exit, stage 1 to last exit
  function automatic logic [MAP_MAX-1:0] chain_map(input int n, input int e);
    logic [MAP_MAX-1:0] m;
    int base;
    m = '0;
    for (int i = 0; i < n; i++) begin
      base = i * (n + e);
      m[base + i] = 1'b1;
      if (i < n - 1) m[base + i + 1] = 1'b1;
      if (i == n - 1) for (int x = 0; x < e; x++) m[base + n + x] = 1'b1;
      if (i == 1 && n > 2) m[base + n + e - 1] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tseq_stage.sv
module tseq_stage #(
  parameter int unsigned N_STAGES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] feed_i,
  input  logic                load_i,
  input  logic                set_i,
  input  logic                clr_i,
  output logic                q_o
);
  logic d;
  assign d = ((|feed_i) | load_i | set_i) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/tseq_exit.sv
module tseq_exit #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned N_EXITS  = 2,
  localparam int unsigned EXIT_W  = (N_EXITS > 1) ? $clog2(N_EXITS) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_EXITS-1:0][N_STAGES-1:0]   col_i,
  output logic                               done_o,
  output logic [EXIT_W-1:0]                  exit_o
);
  logic              hit;
  logic [EXIT_W-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int e = N_EXITS - 1; e >= 0; e--) begin
      if (|col_i[e]) begin
        hit = 1'b1;
        idx = EXIT_W'(e);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      exit_o <= '0;
    end else begin
      done_o <= hit;
      if (hit) exit_o <= idx;
    end
  end
endmodule

// File: rtl/tseq_network.sv
module tseq_network #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned N_EXITS  = 2,
  parameter int unsigned N_STARTS = 2,
  parameter logic [N_STAGES*(N_STAGES+N_EXITS)-1:0] LINK_MAP =
    (N_STAGES*(N_STAGES+N_EXITS))'(tseq_pkg::chain_map(N_STAGES, N_EXITS)),
  parameter logic [N_STARTS*N_STAGES-1:0] ENTRY_MAP =
    {{(N_STAGES-3){1'b0}}, 3'b100, {(N_STAGES-1){1'b0}}, 1'b1},
  localparam int unsigned ROW_W  = N_STAGES + N_EXITS,
  localparam int unsigned EXIT_W = (N_EXITS > 1) ? $clog2(N_EXITS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_STARTS-1:0]       start_i,
  input  logic [N_STAGES*ROW_W-1:0] sel_i,
  input  logic [N_STAGES-1:0]       force_set_i,
  input  logic [N_STAGES-1:0]       force_clr_i,
  output logic [N_STAGES-1:0]       tok_o,
  output logic                      done_o,
  output logic [EXIT_W-1:0]         exit_o
);
  // act[i] : live outgoing link of source i (token & present & chosen)
  logic [N_STAGES-1:0][ROW_W-1:0]    act;
  logic [N_STAGES-1:0][N_STAGES-1:0] feed;   // feed[j][i]
  logic [N_EXITS-1:0][N_STAGES-1:0]  ex_col; // ex_col[e][i]
  logic                              idle;

  assign idle = ~|tok_o;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_src
    assign act[i] = {ROW_W{tok_o[i]}} & sel_i[i*ROW_W +: ROW_W]
                    & LINK_MAP[i*ROW_W +: ROW_W];
    for (genvar j = 0; j < N_STAGES; j++) begin : g_dst
      assign feed[j][i] = act[i][j];
    end
    for (genvar e = 0; e < N_EXITS; e++) begin : g_ex
      assign ex_col[e][i] = act[i][N_STAGES + e];
    end
  end

  for (genvar j = 0; j < N_STAGES; j++) begin : g_stage
    logic [N_STARTS-1:0] entry_hit;
    for (genvar s = 0; s < N_STARTS; s++) begin : g_st
      assign entry_hit[s] = start_i[s] & ENTRY_MAP[s*N_STAGES + j];
    end

    tseq_stage #(.N_STAGES(N_STAGES)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .feed_i (feed[j]),
      .load_i (idle & (|entry_hit)),
      .set_i  (force_set_i[j]),
      .clr_i  (force_clr_i[j]),
      .q_o    (tok_o[j])
    );
  end

  tseq_exit #(.N_STAGES(N_STAGES), .N_EXITS(N_EXITS)) u_exit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .col_i  (ex_col),
    .done_o (done_o),
    .exit_o (exit_o)
  );
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned N_EXITS  = 2,
  parameter int unsigned N_STARTS = 2,
  localparam int unsigned ROW_W   = N_STAGES + N_EXITS,
  localparam int unsigned EXIT_W  = (N_EXITS > 1) ? $clog2(N_EXITS) : 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_STARTS-1:0]       start_i,
  input logic [N_STAGES*ROW_W-1:0] sel_i,
  input logic [N_STAGES-1:0]       force_set_i,
  input logic [N_STAGES-1:0]       force_clr_i,
  input logic [N_STAGES-1:0]       tok_o,
  input logic                      done_o,
  input logic [EXIT_W-1:0]         exit_o
);
  p_idle_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_o == '0 && start_i == '0 && force_set_i == '0) |=> tok_o == '0);

  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_o == '0 && $onehot(start_i) && force_set_i == '0 && force_clr_i == '0)
    |=> $onehot(tok_o));

  p_single_token_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(tok_o) && force_set_i == '0 && (tok_o != '0 || $onehot0(start_i)))
    |=> $onehot0(tok_o));

  p_done_after_token_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tok_o) != '0);

  p_exit_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int'(exit_o) < N_EXITS);
endmodule

bind tseq_network tseq_chk #(
  .N_STAGES(N_STAGES), .N_EXITS(N_EXITS), .N_STARTS(N_STARTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sel_i(sel_i),
  .force_set_i(force_set_i), .force_clr_i(force_clr_i),
  .tok_o(tok_o), .done_o(done_o), .exit_o(exit_o)
);

// File: tb/tseq_network_tb.sv
module tseq_network_tb;
  localparam int N = 8;
  localparam int E = 2;
  localparam int S = 2;
  localparam int W = N + E;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [S-1:0]   start = '0;
  logic [N*W-1:0] sel;
  logic [N-1:0]   fset = '0, fclr = '0;
  logic [N-1:0]   tok;
  logic           done;
  logic           ex;

  int dest [N];
  bit m_tok [N];
  bit m_done;
  int m_exit;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  tseq_network u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sel_i(sel),
    .force_set_i(fset), .force_clr_i(fclr),
    .tok_o(tok), .done_o(done), .exit_o(ex)
  );

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) sel[i*W + dest[i]] = 1'b1;
  end

  // R10 default connections
  function automatic bit link_ok(int i, int d);
    return d == i || (d == i + 1 && i < N - 1) || (i == N - 1 && d >= N)
           || (i == 1 && d == N + E - 1);
  endfunction

  function automatic logic [N-1:0] mvec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_tok[i];
    return v;
  endfunction

  task automatic model_next();
    bit nt [N];
    bit idle = 1;
    bit hit = 0;
    int first = 0;
    for (int i = 0; i < N; i++) if (m_tok[i]) idle = 0;
    for (int j = 0; j < N; j++) nt[j] = 0;
    for (int i = 0; i < N; i++)
      if (m_tok[i] && link_ok(i, dest[i])) begin
        if (dest[i] < N) nt[dest[i]] = 1;
        else if (!hit || dest[i] - N < first) begin
          hit = 1; first = dest[i] - N;
        end
      end
    if (idle && start[0]) nt[0] = 1;
    if (idle && start[1]) nt[2] = 1;
    for (int j = 0; j < N; j++) begin
      if (fset[j]) nt[j] = 1;
      if (fclr[j]) nt[j] = 0;
    end
    for (int j = 0; j < N; j++) m_tok[j] = nt[j];
    m_done = hit;
    if (hit) m_exit = first;
  endtask

  task automatic compare(string tag);
    checks++;
    if (tok !== mvec() || done !== m_done || (m_done && int'(ex) != m_exit)) begin
      fails++;
      $display("FAIL %s: tok=%b done=%b exit=%0d expected tok=%b done=%b exit=%0d",
               tag, tok, done, ex, mvec(), m_done, m_exit);
    end
  endtask

  task automatic step(string tag);
    model_next();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    start = '0; fset = '0; fclr = '0;
  endtask

  task automatic all_hold();
    for (int i = 0; i < N; i++) dest[i] = i;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    all_hold();
    for (int j = 0; j < N; j++) m_tok[j] = 0;
    m_done = 0; m_exit = 0;
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step("R1 idle after reset");
    step("R1 idle after reset");

    // R2 start 0, R5 hold, R4 chain, R7 exit 0
    start = 2'b01; step("R2 start0 entry");
    step("R5 hold in stage0");
    step("R5 hold in stage0");
    start = 2'b01; step("R3 start ignored busy");
    for (int k = 0; k < N - 1; k++) begin
      dest[k] = k + 1; step("R4 advance");
      dest[k] = k;
    end
    dest[N-1] = N; step("R7 exit0 clears");
    all_hold();
    step("R7 done single pulse");

    // R2 start 1, R6 absent link
    start = 2'b10; step("R2 start1 entry stage2");
    start = 2'b10; step("R3 start1 ignored busy");
    dest[2] = 5; step("R6 absent link drops");
    all_hold();
    step("R6 no done after drop");

    // R7 early exit 1 from stage 1
    start = 2'b01; step("R2 start0");
    dest[0] = 1; step("R4 to stage1");
    all_hold();
    dest[1] = N + 1; step("R7 exit1");
    all_hold();
    step("R7 idle after exit1");

    // R8 two exits same edge via forced extra token
    start = 2'b01; step("R2 start0");
    dest[0] = 1; fset[N-1] = 1'b1; step("R9 force set stage7");
    all_hold();
    dest[1] = N + 1; dest[N-1] = N; step("R8 double exit lowest");
    all_hold();
    step("R8 idle after double exit");

    // R9 clear wins over set
    start = 2'b01; step("R2 start0");
    fset[0] = 1'b1; fclr[0] = 1'b1; fset[4] = 1'b1; step("R9 clr wins, set 4");
    fclr[4] = 1'b1; step("R9 force clear");
    step("R9 idle");

    // R2 both starts together
    start = 2'b11; step("R2 both starts");
    dest[0] = 1; dest[2] = 3; step("R4 two tokens move");
    all_hold();
    fclr = '1; step("R9 clear all");
    step("R1 idle end");

    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule